// File: doc/BRIEF.md
# Network Controller Command Register and Control

This block holds the command register of a classic ISA-style Ethernet controller, together with the control logic that reacts to command writes. A write to the command register is decoded into a stop state, a start state, a two-bit page select, a three-bit remote-DMA command and a transmit request. An illegal remote-DMA code of zero is replaced by the safe "abort/complete" code 4 before decoding. The reset status bit is set whenever the stop bit is written. It is held until a write raises the start bit from zero.

The block keeps an interrupt status register and an interrupt mask register. It drives a level interrupt that is high while any enabled status bit is set. A transmit request in internal loopback completes at once. A normal transmit arms a microsecond timer whose length follows the frame length. A send-packet remote-DMA command copies the boundary page into the remote start and current address. It then fetches the frame length word from packet memory through a one-word read port. A zero-byte remote read issued while started flags remote-DMA completion at once.

Top module: `eth_cmd_ctrl`

## Requirements
- R1: After reset, stop_o=1, start_o=0, page_o=0, rdma_o=4, isr_o=0x04 (only the reset bit), imr_o=0, irq_o=0, tx_busy_o=0, rmt_count_o=0.
- R2: Writes use wr_addr 0=command, 1=status write-one-to-clear, 2=mask, 3=boundary page, 4=transmit count low byte, 5=transmit count high byte, 6=loopback mode (bits 1:0). One cycle after a command write, page_o shows bits 7:6, rdma_o shows bits 5:3, start_o shows bit 1 and stop_o shows bit 0.
- R3: A command write whose bits 5:3 are all zero is decoded with bit 5 set, so rdma_o becomes 4.
- R4: A command write with bit 0 set sets stop_o and status bit 2 (reset); with bit 0 clear it clears stop_o.
- R5: Status bit 2 clears only on a command write with bit 1 set while start_o was 0. Such a write wins over a bit-0 set in the same write. A write-one-to-clear of the status register has no effect on bit 2.
- R6: A command write with remote-DMA code 3 sets rmt_start_o and rmt_addr_o to boundary×256 on the next cycle. It drives mem_raddr_o to boundary×256+2 and pulses mem_rd_o. It loads rmt_count_o from mem_rdata_i (low byte = memory byte at offset 2, high byte = offset 3) within two cycles of the write.
- R7: A command write with bit 2 set while the loopback mode is 1 sets status bit 0 (transmit done) on the next cycle.
- R8: A command write with bit 2 set, loopback mode 0, and the decoded stop=0 and start=1 arms the timer with (192 + 8×count)/10 microsecond ticks, where count is the 16-bit transmit count. tx_busy_o is high while armed. Status bit 0 sets on the edge of the final tick and not before.
- R9: A transmit request with the decoded stop=1, the decoded start=0, or loopback mode 2 or 3 is ignored: tx_busy_o stays low and status bit 0 stays clear.
- R10: A command write with remote-DMA code 1 and bit 1 set while rmt_count_o is zero sets status bit 1 (remote DMA done). With a non-zero count it does not.
- R11: irq_o is high exactly when some bit of isr_o & imr_o is set. Writing ones to the status register clears bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| mem_raddr_o | output | 16 | Packet memory word address (length field) |
| mem_rd_o | output | 1 | Packet memory read strobe |
| mem_rdata_i | input | 16 | Packet memory read data, sampled while mem_rd_o is high |
| stop_o | output | 1 | Stop state |
| start_o | output | 1 | Start state |
| page_o | output | 2 | Register page select |
| rdma_o | output | 3 | Remote-DMA command code |
| rmt_start_o | output | 16 | Remote-DMA start address |
| rmt_addr_o | output | 16 | Remote-DMA current address |
| rmt_count_o | output | 16 | Remote-DMA byte count |
| isr_o | output | 8 | Interrupt status (bit0 tx done, bit1 remote DMA done, bit2 reset) |
| imr_o | output | 8 | Interrupt mask |
| irq_o | output | 1 | Interrupt request level |
| tx_busy_o | output | 1 | Transmit timer armed |

## Verification
The assertions check several rules on every cycle. Page select follows each command write, and a zero remote-DMA code is always replaced by 4. The reset status bit falls only after a start-raising write, and is set by a stop write that does not also raise start. Transmit-done and remote-DMA-done rise only from their own causes, and an accepted normal transmit always arms the timer. Other properties need the bench's scenarios. These include the exact timer length for given byte counts, the length word fetched from memory and its byte order, and the suppression of the zero-byte probe once a count is loaded. The bench also checks that stopped or unsupported-loopback transmits leave no trace, and the masking and clearing of the interrupt.

// File: rtl/eth_cr_pkg.sv
package eth_cr_pkg;

  localparam int ISR_W   = 8;
  localparam int BIT_TXD = 0;   // transmit done
  localparam int BIT_RDD = 1;   // remote DMA done
  localparam int BIT_RST = 2;   // reset status

  localparam logic [2:0] RD_PROBE = 3'd1;
  localparam logic [2:0] RD_SEND  = 3'd3;

  typedef struct packed {
    logic [1:0] page;
    logic [2:0] rdma;
    logic       txp;
    logic       start;
    logic       stop;
  } cmd_t;

  // Replace a zero remote-DMA code by code 4 (R3)
  function automatic logic [7:0] fix_rdma(input logic [7:0] v);
    return (v[5:3] == 3'd0) ? (v | 8'h20) : v;
  endfunction

  // Transmit completion delay in microseconds:
  // preamble 64 + gap 96 + CRC 32 + 8 per byte, divided by 10 (R8)
  function automatic int unsigned tx_delay_us(input int unsigned nbytes);
    return (32'd64 + 32'd96 + 32'd32 + 32'd8 * nbytes) / 32'd10;
  endfunction

endpackage

// File: rtl/eth_cr_decode.sv
module eth_cr_decode
  import eth_cr_pkg::*;
(
  input  logic [7:0] val,
  output cmd_t       cmd
);
  always_comb cmd = cmd_t'(fix_rdma(val));
endmodule

// File: rtl/eth_tx_timer.sv
module eth_tx_timer #(
  parameter int TW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          busy,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  assign done = busy && tick && !load && (cnt_q == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      busy  <= (load_val != '0);
    end else if (busy && tick) begin
      cnt_q <= cnt_q - TW'(1);
      if (cnt_q == TW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/eth_int_status.sv
module eth_int_status #(
  parameter int              W         = 8,
  parameter logic [W-1:0]    RST_VAL   = '0,
  parameter logic [W-1:0]    W1C_MASK  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] w1c_v,
  input  logic [W-1:0] hard_clr,
  input  logic         mask_we,
  input  logic [W-1:0] mask_d,
  output logic [W-1:0] isr,
  output logic [W-1:0] imr,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr <= RST_VAL;
      imr <= '0;
    end else begin
      isr <= ((isr & ~(w1c_v & W1C_MASK)) | set_v) & ~hard_clr;
      if (mask_we) imr <= mask_d;
    end
  end

  assign irq = |(isr & imr);  // R11
endmodule

// File: rtl/eth_cmd_ctrl.sv
module eth_cmd_ctrl
  import eth_cr_pkg::*;
#(
  parameter int CW = 16,   // transmit / remote byte count width
  parameter int PW = 8     // page number width
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              us_tick,
  output logic [PW+7:0]     mem_raddr_o,
  output logic              mem_rd_o,
  input  logic [CW-1:0]     mem_rdata_i,
  output logic              stop_o,
  output logic              start_o,
  output logic [1:0]        page_o,
  output logic [2:0]        rdma_o,
  output logic [PW+7:0]     rmt_start_o,
  output logic [PW+7:0]     rmt_addr_o,
  output logic [CW-1:0]     rmt_count_o,
  output logic [ISR_W-1:0]  isr_o,
  output logic [ISR_W-1:0]  imr_o,
  output logic              irq_o,
  output logic              tx_busy_o
);
  localparam int AW = PW + 8;
  localparam int TW = CW + 5;
  localparam logic [ISR_W-1:0] RST_STAT = ISR_W'(1) << BIT_RST;
  localparam logic [ISR_W-1:0] W1C_OK   = ~RST_STAT;   // R5

  // write decode
  logic cmd_wr, isr_wr, imr_wr, bnd_wr, cnl_wr, cnh_wr, lpb_wr;
  assign cmd_wr = wr_en && (wr_addr == 3'd0);
  assign isr_wr = wr_en && (wr_addr == 3'd1);
  assign imr_wr = wr_en && (wr_addr == 3'd2);
  assign bnd_wr = wr_en && (wr_addr == 3'd3);
  assign cnl_wr = wr_en && (wr_addr == 3'd4);
  assign cnh_wr = wr_en && (wr_addr == 3'd5);
  assign lpb_wr = wr_en && (wr_addr == 3'd6);

  cmd_t dc;
  eth_cr_decode u_dec (.val(wr_data), .cmd(dc));

  logic [PW-1:0] bnd_q;
  logic [CW-1:0] txcnt_q;
  logic [1:0]    lpb_q;
  logic          rd_pend_q;

  // named internal events (R5, R7, R8, R10, R6)
  logic start_edge, tx_loop, tx_norm, probe_hit, send_pkt, tmr_done;
  assign start_edge = cmd_wr && dc.start && !start_o;
  assign tx_loop    = cmd_wr && dc.txp && (lpb_q == 2'd1);
  assign tx_norm    = cmd_wr && dc.txp && (lpb_q == 2'd0) && !dc.stop && dc.start;
  assign probe_hit  = cmd_wr && (dc.rdma == RD_PROBE) && dc.start && (rmt_count_o == '0);
  assign send_pkt   = cmd_wr && (dc.rdma == RD_SEND);

  // command state (R1, R2, R4)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_o  <= 1'b1;
      start_o <= 1'b0;
      page_o  <= 2'd0;
      rdma_o  <= 3'd4;
    end else if (cmd_wr) begin
      stop_o  <= dc.stop;
      start_o <= dc.start;
      page_o  <= dc.page;
      rdma_o  <= dc.rdma;
    end
  end

  // side registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bnd_q   <= '0;
      txcnt_q <= '0;
      lpb_q   <= 2'd0;
    end else begin
      if (bnd_wr) bnd_q <= PW'(wr_data);
      if (cnl_wr) txcnt_q[7:0] <= wr_data;
      if (cnh_wr) txcnt_q[CW-1:8] <= (CW-8)'(wr_data);
      if (lpb_wr) lpb_q <= wr_data[1:0];
    end
  end

  // send-packet address setup and length fetch (R6)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmt_start_o <= '0;
      rmt_addr_o  <= '0;
      rmt_count_o <= '0;
      rd_pend_q   <= 1'b0;
    end else begin
      rd_pend_q <= send_pkt;
      if (send_pkt) begin
        rmt_start_o <= {bnd_q, 8'h00};
        rmt_addr_o  <= {bnd_q, 8'h00};
      end
      if (rd_pend_q) rmt_count_o <= mem_rdata_i;
    end
  end
  assign mem_rd_o    = rd_pend_q;
  assign mem_raddr_o = rmt_start_o | AW'(2);

  // transmit timer (R8)
  logic [TW-1:0] tmr_len;
  assign tmr_len = TW'(tx_delay_us(32'(txcnt_q)));

  eth_tx_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tx_norm), .load_val(tmr_len),
    .tick(us_tick), .busy(tx_busy_o), .done(tmr_done)
  );

  // status and interrupt (R4, R5, R7, R10, R11)
  logic [ISR_W-1:0] set_v, clr_v, w1c_v;
  always_comb begin
    set_v = '0;
    set_v[BIT_TXD] = tx_loop || tmr_done;
    set_v[BIT_RDD] = probe_hit;
    set_v[BIT_RST] = cmd_wr && dc.stop;
    clr_v = '0;
    clr_v[BIT_RST] = start_edge;
    w1c_v = isr_wr ? wr_data : '0;
  end

  eth_int_status #(.W(ISR_W), .RST_VAL(RST_STAT), .W1C_MASK(W1C_OK)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .w1c_v(w1c_v), .hard_clr(clr_v),
    .mask_we(imr_wr), .mask_d(wr_data), .isr(isr_o), .imr(imr_o), .irq(irq_o)
  );
endmodule

module eth_cmd_ctrl_chk
  import eth_cr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic [7:0]       wdata,
  input logic             start_o,
  input logic [1:0]       page_o,
  input logic [2:0]       rdma_o,
  input logic [ISR_W-1:0] isr_o,
  input logic             tmr_done,
  input logic             tx_loop,
  input logic             tx_norm,
  input logic             probe_hit,
  input logic             tx_busy
);
  AST_PAGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> page_o == $past(wdata[7:6])); // R2
  AST_RDMA_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[5:3] == 3'd0) |=> rdma_o == 3'd4); // R3
  AST_RST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[0] && !(wdata[1] && !start_o)) |=> isr_o[BIT_RST]); // R4
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(isr_o[BIT_RST]) |-> $past(cmd_wr && wdata[1] && !start_o)); // R5
  AST_TXD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr_o[BIT_TXD]) |-> $past(tmr_done || tx_loop)); // R7
  AST_TMR_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    tx_norm |=> tx_busy); // R8
  AST_RDD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr_o[BIT_RDD]) |-> $past(probe_hit)); // R10
endmodule

bind eth_cmd_ctrl eth_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(wr_data),
  .start_o(start_o), .page_o(page_o), .rdma_o(rdma_o), .isr_o(isr_o),
  .tmr_done(tmr_done), .tx_loop(tx_loop), .tx_norm(tx_norm),
  .probe_hit(probe_hit), .tx_busy(tx_busy_o)
);

// File: tb/sim_eth_cmd_ctrl.sv
module sim_eth_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        us_tick = 1'b0;
  logic [15:0] mem_raddr, mem_rdata;
  logic        mem_rd;
  logic        stop_o, start_o, irq_o, tx_busy;
  logic [1:0]  page_o;
  logic [2:0]  rdma_o;
  logic [15:0] rmt_start, rmt_addr, rmt_count;
  logic [7:0]  isr_o, imr_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  // packet memory model: byte value derived from its address
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign mem_rdata = {mem_byte(mem_raddr + 16'd1), mem_byte(mem_raddr)};

  eth_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .us_tick(us_tick), .mem_raddr_o(mem_raddr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
    .stop_o(stop_o), .start_o(start_o), .page_o(page_o), .rdma_o(rdma_o),
    .rmt_start_o(rmt_start), .rmt_addr_o(rmt_addr), .rmt_count_o(rmt_count),
    .isr_o(isr_o), .imr_o(imr_o), .irq_o(irq_o), .tx_busy_o(tx_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
    end
  endtask

  function automatic int delay_of(input int n);
    return (192 + n * 8) / 10;
  endfunction

  task automatic t_reset;
    check("R1 stop", stop_o, 1);
    check("R1 start", start_o, 0);
    check("R1 page", page_o, 0);
    check("R1 rdma", rdma_o, 4);
    check("R1 isr", isr_o, 8'h04);
    check("R1 imr/irq", {imr_o, irq_o}, 0);
    check("R1 busy/count", {tx_busy, rmt_count}, 0);
  endtask

  task automatic t_decode;
    wr(3'd1, 8'hFF);
    check("R5 w1c keeps reset bit", isr_o, 8'h04);
    wr(3'd0, 8'h01);
    check("R3 zero code forced", rdma_o, 4);
    check("R4 stop set", stop_o, 1);
    wr(3'd0, 8'h62);
    check("R2 page", page_o, 1);
    check("R2 start/stop", {start_o, stop_o}, 2'b10);
    check("R5 start edge clears reset", isr_o[2], 0);
    wr(3'd0, 8'h63);
    check("R4 stop sets reset bit, no edge", isr_o[2], 1);
    wr(3'd0, 8'hC2);
    check("R2 page 3", page_o, 3);
    check("R4 stop cleared", stop_o, 0);
    check("R5 no edge keeps reset", isr_o[2], 1);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h03);
    check("R5 clear wins over set", isr_o[2], 0);
    check("R4 stop", stop_o, 1);
    check("R2 rdma after 0x00/0x03", rdma_o, 4);
  endtask

  task automatic t_probe;
    wr(3'd0, 8'h0A);
    check("R10 zero probe", isr_o, 8'h02);
    check("R11 masked", irq_o, 0);
    wr(3'd2, 8'h02);
    check("R11 enabled", irq_o, 1);
    wr(3'd1, 8'h02);
    check("R11 w1c", {isr_o, irq_o}, 0);
  endtask

  task automatic t_send;
    wr(3'd3, 8'h12);
    wr(3'd0, 8'h1A);
    check("R6 start addr", rmt_start, 16'h1200);
    check("R6 current addr", rmt_addr, 16'h1200);
    check("R6 read addr", mem_raddr, 16'h1202);
    @(negedge clk);
    check("R6 length word", rmt_count, {mem_byte(16'h1203), mem_byte(16'h1202)});
    wr(3'd0, 8'h0A);
    check("R10 nonzero count no done", isr_o[1], 0);
  endtask

  task automatic t_loop;
    wr(3'd6, 8'h01);
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h26);
    check("R7 loopback done", isr_o[0], 1);
    check("R7 irq", irq_o, 1);
    check("R7 no timer", tx_busy, 0);
    wr(3'd1, 8'h01);
  endtask

  task automatic t_timer(input int n);
    int d;
    d = delay_of(n);
    wr(3'd6, 8'h00);
    wr(3'd4, 8'(n));
    wr(3'd5, 8'(n >> 8));
    wr(3'd0, 8'h26);
    check("R8 armed", tx_busy, 1);
    ticks(d - 1);
    check("R8 not early", {tx_busy, isr_o[0]}, 2'b10);
    ticks(1);
    check("R8 done on last tick", {tx_busy, isr_o[0]}, 2'b01);
    wr(3'd1, 8'h01);
  endtask

  task automatic t_ignore;
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h25);
    check("R9 stopped", {tx_busy, isr_o[0]}, 0);
    wr(3'd0, 8'h24);
    check("R9 not started", {tx_busy, isr_o[0]}, 0);
    wr(3'd6, 8'h02);
    wr(3'd0, 8'h26);
    ticks(30);
    check("R9 loop mode 2", {tx_busy, isr_o[0]}, 0);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_decode;
    t_probe;
    t_send;
    t_loop;
    t_timer(10);
    t_timer(257);
    t_ignore;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule